// File: doc/BRIEF.md
# Sequential Byte Multiply/Divide Unit

This unit performs unsigned 8-bit by 8-bit multiplication and 8-bit by 8-bit division over several clocks. A caller presents two operand bytes, an operation select and a one-clock start pulse. The unit captures the operands, reports busy for a fixed number of machine cycles and then pulses done. At that point two result bytes and two flags are valid.

The result bytes follow the accumulator/B-register convention. After a multiply, the first result byte holds the low half of the 16-bit product and the second holds the high half. After a divide, the first byte holds the quotient and the second holds the remainder. The carry flag is always cleared. The overflow flag marks a product above 255, or a zero divisor.

A machine cycle spans a parameterised number of clocks. Multiply takes four machine cycles and divide takes eight, whatever the operand values. The multiply array retires two multiplier bits per machine cycle. The divider runs restoring shift-subtract and produces one quotient bit per machine cycle.

Top module: `muldiv_seq`

## Requirements
- R1: After reset, busy_o, done_o, a_o, b_o, cy_o and ov_o are all 0.
- R2: A start accepted while idle with op_div_i = 0 (multiply) raises busy_o on the next clock. done_o is high exactly 4 × CLKS_PER_MC clocks after the clock edge that sampled start_i.
- R3: A start accepted while idle with op_div_i = 1 (divide) gives done_o exactly 8 × CLKS_PER_MC clocks after the sampling edge.
- R4: done_o is high for exactly one clock. busy_o is low whenever done_o is high. Each accepted start produces exactly one done_o.
- R5: start_i is ignored while busy_o is high. The running operation is neither restarted nor changed, and its result and latency are unaffected.
- R6: On a multiply, a_o receives bits 7:0 and b_o receives bits 15:8 of the unsigned product a_i × b_i.
- R7: On a multiply, ov_o is 1 exactly when the product exceeds 255, and cy_o is 0.
- R8: On a divide with a nonzero divisor, a_o is the integer quotient, b_o is the remainder, and ov_o and cy_o are 0.
- R9: On a divide by zero, ov_o is 1, cy_o is 0, a_o keeps the dividend and b_o keeps the divisor (0).
- R10: a_o, b_o, cy_o and ov_o change only on the clock where done_o rises. They hold steady while busy and between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| op_div_i | input | 1 | Operation: 0 multiply, 1 divide |
| a_i | input | W | Operand A (multiplicand or dividend) |
| b_i | input | W | Operand B (multiplier or divisor) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| a_o | output | W | Product low byte or quotient |
| b_o | output | W | Product high byte or remainder |
| cy_o | output | 1 | Carry flag, always cleared |
| ov_o | output | 1 | Overflow: product > 255 or zero divisor |

## Verification
The bench drives products on both sides of the 255 boundary: 0x0F × 0x11 must give no overflow, while 0x10 × 0x10 and 0xFF × 0xFF must give overflow. A multiplier that dropped a partial product or mis-shifted the high half would return a wrong b_o or a stale overflow flag.

Divides by 1, by 255 and by a divisor larger than the dividend probe the quotient extremes of the restoring loop. A divide by zero must hand back the untouched operands with overflow set. A wrong subtract test would leave a remainder not below the divisor, or shift a garbage quotient into a_o.

A start raised with different operands in mid-operation must leave the first result and its latency unchanged. Every completion is timed to the exact clock, so an off-by-one in the machine-cycle counter shows up as a mis-timed done.

// File: rtl/muldiv_pkg.sv
// Package: shared operation encoding for the byte multiply/divide unit.
// Assumes one select bit; the value 1 means divide.
package muldiv_pkg;
    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;
endpackage

// File: rtl/md_seq_ctrl.sv
// Sequencer: accepts a start while idle and counts clocks within each
// machine cycle and machine cycles within the operation. It issues one
// step strobe at the first clock of every machine cycle and a finish
// strobe on the last clock of the last machine cycle.
// Assumes CLKS_PER_MC >= 1 and machine-cycle counts >= 1.
module md_seq_ctrl
    import muldiv_pkg::*;
#(
    parameter int CLKS_PER_MC = 2,
    parameter int MUL_MC      = 4,
    parameter int DIV_MC      = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  md_op_e op_i,
    output logic   accept_o,
    output logic   busy_o,
    output logic   step_o,
    output logic   finish_o,
    output md_op_e op_o
);
    localparam int MAX_MC = (MUL_MC > DIV_MC) ? MUL_MC : DIV_MC;
    localparam int SUB_W  = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
    localparam int MC_W   = (MAX_MC > 1) ? $clog2(MAX_MC) : 1;

    logic             busy_r;
    logic [SUB_W-1:0] sub_r;
    logic [MC_W-1:0]  mc_r;
    md_op_e           op_r;
    logic [MC_W-1:0]  mc_last;
    logic             sub_last;

    // Decode the end of the current machine cycle and of the operation.
    always_comb begin
        mc_last  = (op_r == OP_DIV) ? MC_W'(DIV_MC - 1) : MC_W'(MUL_MC - 1);
        sub_last = (sub_r == SUB_W'(CLKS_PER_MC - 1));
        accept_o = start_i && !busy_r;
        step_o   = busy_r && (sub_r == '0);
        finish_o = busy_r && sub_last && (mc_r == mc_last);
    end

    // Advance the clock and machine-cycle counters while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_r <= 1'b0;
            sub_r  <= '0;
            mc_r   <= '0;
            op_r   <= OP_MUL;
        end else if (accept_o) begin
            busy_r <= 1'b1;
            sub_r  <= '0;
            mc_r   <= '0;
            op_r   <= op_i;
        end else if (busy_r) begin
            if (sub_last) begin
                sub_r <= '0;
                if (mc_r == mc_last) busy_r <= 1'b0;
                else                 mc_r   <= mc_r + 1'b1;
            end else begin
                sub_r <= sub_r + 1'b1;
            end
        end
    end

    assign busy_o = busy_r;
    assign op_o   = op_r;

    // R5: a start seen mid-operation neither ends nor changes it.
    a_r5_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_r && !finish_o) |=> (busy_r && $stable(op_r)));
endmodule

// File: rtl/md_mul_core.sv
// Multiply datapath: shift-add, retiring W/STEPS multiplier bits per step.
// Exposes the product as it will be after the current strobe, so the
// final step and the capture may share a clock.
// Assumes STEPS divides W.
module md_mul_core #(
    parameter int W     = 8,
    parameter int STEPS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    input  logic         step_i,
    output logic [2*W-1:0] prod_nxt_o
);
    localparam int K = W / STEPS;

    logic [2*W-1:0] acc_r, mcand_r, addend, acc_step;
    logic [W-1:0]   mplier_r;

    // Form the partial sum for the K low multiplier bits.
    always_comb begin
        addend = '0;
        for (int j = 0; j < K; j++)
            if (mplier_r[j]) addend = addend + (mcand_r << j);
        acc_step   = acc_r + addend;
        prod_nxt_o = step_i ? acc_step : acc_r;
    end

    // Load operands on accept; shift and accumulate on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_r    <= '0;
            mcand_r  <= '0;
            mplier_r <= '0;
        end else if (load_i) begin
            acc_r    <= '0;
            mcand_r  <= {{W{1'b0}}, mcand_i};
            mplier_r <= mplier_i;
        end else if (step_i) begin
            acc_r    <= acc_step;
            mcand_r  <= mcand_r << K;
            mplier_r <= mplier_r >> K;
        end
    end
endmodule

// File: rtl/md_div_core.sv
// Divide datapath: restoring shift-subtract, one quotient bit per step.
// The dividend shifts out of the quotient register as quotient bits
// shift in. Exposes the post-strobe quotient and remainder.
// Assumes exactly W steps follow each load.
module md_div_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    input  logic         step_i,
    output logic [W-1:0] quo_nxt_o,
    output logic [W-1:0] rem_nxt_o
);
    logic [W-1:0] quo_r, rem_r, dvs_r, quo_step, rem_step;
    logic [W:0]   trial, diff;
    logic         fits;

    // Trial subtract of the divisor from the shifted partial remainder.
    always_comb begin
        trial    = {rem_r, quo_r[W-1]};
        diff     = trial - {1'b0, dvs_r};
        fits     = (trial >= {1'b0, dvs_r});
        rem_step = fits ? diff[W-1:0] : trial[W-1:0];
        quo_step = {quo_r[W-2:0], fits};
        quo_nxt_o = step_i ? quo_step : quo_r;
        rem_nxt_o = step_i ? rem_step : rem_r;
    end

    // Load on accept; take one restoring step per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_r <= '0;
            rem_r <= '0;
            dvs_r <= '0;
        end else if (load_i) begin
            quo_r <= dvd_i;
            rem_r <= '0;
            dvs_r <= dvs_i;
        end else if (step_i) begin
            quo_r <= quo_step;
            rem_r <= rem_step;
        end
    end

    // R8: after any step with a nonzero divisor the remainder stays below it.
    a_r8_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && dvs_r != '0) |=> (rem_r < dvs_r));
endmodule

// File: rtl/muldiv_seq.sv
// Top: sequential unsigned byte multiply/divide with a start/busy/done
// handshake. Operands are captured on an accepted start. Results and
// flags are registered on the finishing clock and held until the next one.
// Assumes the caller keeps its own copies of A and B.
module muldiv_seq
    import muldiv_pkg::*;
#(
    parameter int W           = 8,
    parameter int CLKS_PER_MC = 2,
    parameter int MUL_MC      = 4,
    parameter int DIV_MC      = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         op_div_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output logic         cy_o,
    output logic         ov_o
);
    logic           accept, step, finish;
    md_op_e         op_cur;
    logic [W-1:0]   a_r, b_r, quo_nxt, rem_nxt;
    logic [2*W-1:0] prod_nxt;
    logic           step_mul, step_div;

    md_seq_ctrl #(.CLKS_PER_MC(CLKS_PER_MC), .MUL_MC(MUL_MC), .DIV_MC(DIV_MC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(md_op_e'(op_div_i)),
        .accept_o(accept), .busy_o(busy_o), .step_o(step), .finish_o(finish),
        .op_o(op_cur)
    );

    // Route the step strobe to the datapath of the running operation.
    always_comb begin
        step_mul = step && (op_cur == OP_MUL);
        step_div = step && (op_cur == OP_DIV);
    end

    md_mul_core #(.W(W), .STEPS(MUL_MC)) u_mul (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .mcand_i(a_i), .mplier_i(b_i),
        .step_i(step_mul), .prod_nxt_o(prod_nxt)
    );

    md_div_core #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .dvd_i(a_i), .dvs_i(b_i),
        .step_i(step_div), .quo_nxt_o(quo_nxt), .rem_nxt_o(rem_nxt)
    );

    // Keep the accepted operands for the divide-by-zero hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r <= '0;
            b_r <= '0;
        end else if (accept) begin
            a_r <= a_i;
            b_r <= b_i;
        end
    end

    // Register results, flags and the done pulse on the finishing clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_o    <= '0;
            b_o    <= '0;
            cy_o   <= 1'b0;
            ov_o   <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= finish;
            if (finish) begin
                cy_o <= 1'b0;
                if (op_cur == OP_MUL) begin
                    a_o  <= prod_nxt[W-1:0];
                    b_o  <= prod_nxt[2*W-1:W];
                    ov_o <= |prod_nxt[2*W-1:W];
                end else if (b_r == '0) begin
                    a_o  <= a_r;
                    b_o  <= b_r;
                    ov_o <= 1'b1;
                end else begin
                    a_o  <= quo_nxt;
                    b_o  <= rem_nxt;
                    ov_o <= 1'b0;
                end
            end
        end
    end

    // R4: done lasts one clock and never coincides with busy.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r4_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R10: results move only with a completion.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({a_o, b_o, cy_o, ov_o}));
    // R7: carry is cleared by every operation.
    a_r7_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cy_o);
    // R7: multiply overflow follows a nonzero high byte.
    a_r7_mul_ov: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_cur == OP_MUL) |-> (ov_o == (b_o != '0)));
    // R9: a divide reporting overflow hands back the zero divisor.
    a_r9_dz_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_cur == OP_DIV && ov_o) |-> (b_o == '0));
endmodule

// File: tb/tb_muldiv_seq.sv
// Scoreboard bench: the driver queues expected results, the monitor pops
// and compares each one when done_o appears.
module tb_muldiv_seq;
    localparam int CPM   = 2;
    localparam int MUL_N = 4 * CPM;
    localparam int DIV_N = 8 * CPM;

    typedef struct packed {
        logic [31:0] due;
        logic [7:0]  ea;
        logic [7:0]  eb;
        logic        eov;
        logic        div;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, op_div_i = 1'b0;
    logic [7:0] a_i = '0, b_i = '0;
    logic busy_o, done_o, cy_o, ov_o;
    logic [7:0] a_o, b_o;

    exp_t sb[$];
    exp_t cur;
    int cyc = 0;
    int n_chk = 0, n_bad = 0;
    logic [17:0] prev_out = '0;
    logic prev_done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    muldiv_seq #(.CLKS_PER_MC(CPM)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_div_i(op_div_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
        .a_o(a_o), .b_o(b_o), .cy_o(cy_o), .ov_o(ov_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic div, input logic [7:0] a, input logic [7:0] b);
        exp_t e;
        logic [15:0] p;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        start_i = 1'b1; op_div_i = div; a_i = a; b_i = b;
        e.div = div;
        if (!div) begin
            p = 16'(a) * 16'(b);
            e.ea = p[7:0]; e.eb = p[15:8]; e.eov = |p[15:8];
        end else if (b == 8'd0) begin
            e.ea = a; e.eb = 8'd0; e.eov = 1'b1;
        end else begin
            e.ea = a / b; e.eb = a % b; e.eov = 1'b0;
        end
        e.due = 32'(cyc + 1 + (div ? DIV_N : MUL_N));
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Monitor: compare each completion and watch for drift or extra pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && prev_done) check(0, "R4", "done longer than one clock", 1, 0);
            if (done_o) begin
                if (sb.size() == 0) begin
                    check(0, "R4", "unexpected done", 1, 0);
                end else begin
                    cur = sb.pop_front();
                    check(cyc == int'(cur.due), cur.div ? "R3" : "R2", "latency", cyc, int'(cur.due));
                    check(a_o == cur.ea, cur.div ? (cur.eov ? "R9" : "R8") : "R6", "a_o", a_o, cur.ea);
                    check(b_o == cur.eb, cur.div ? (cur.eov ? "R9" : "R8") : "R6", "b_o", b_o, cur.eb);
                    check(ov_o == cur.eov, cur.div ? (cur.eov ? "R9" : "R8") : "R7", "ov_o", ov_o, cur.eov);
                    check(cy_o == 1'b0, cur.div ? "R8" : "R7", "cy_o", cy_o, 0);
                    check(!busy_o, "R4", "busy at done", busy_o, 0);
                end
                prev_out <= {a_o, b_o, cy_o, ov_o};
            end else if ({a_o, b_o, cy_o, ov_o} != prev_out) begin
                check(0, "R10", "outputs moved without done", {a_o, b_o, cy_o, ov_o}, prev_out);
                prev_out <= {a_o, b_o, cy_o, ov_o};
            end
            prev_done <= done_o;
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({busy_o, done_o, a_o, b_o, cy_o, ov_o} == '0, "R1", "reset state",
              {busy_o, done_o, a_o, b_o, cy_o, ov_o}, 0);

        // R6/R7: overflow boundary and extremes
        issue(1'b0, 8'h00, 8'h55);
        issue(1'b0, 8'h0F, 8'h11);
        issue(1'b0, 8'h10, 8'h10);
        issue(1'b0, 8'hFF, 8'hFF);
        // R8/R9: quotient extremes and zero divisor
        issue(1'b1, 8'hFF, 8'h10);
        issue(1'b1, 8'h07, 8'h09);
        issue(1'b1, 8'hC8, 8'h01);
        issue(1'b1, 8'hFF, 8'hFF);
        issue(1'b1, 8'hAB, 8'h00);

        // R5: a different start mid-operation must be ignored
        issue(1'b0, 8'h12, 8'h34);
        start_i = 1'b1; op_div_i = 1'b1; a_i = 8'h99; b_i = 8'h03;
        @(negedge clk);
        check(busy_o == 1'b1, "R5", "busy during ignored start", busy_o, 1);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R5", "busy after ignored start", busy_o, 1);

        // Mixed pseudo-random operations
        for (int i = 0; i < 24; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            issue(lf[0], lf[15:8], (i % 7 == 3) ? 8'h00 : lf[7:0]);
        end

        while (sb.size() != 0) @(negedge clk);
        repeat (DIV_N + 4) @(negedge clk);
        // R4: every start yielded exactly one done
        check(sb.size() == 0, "R4", "pending results", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule